// File: doc/BRIEF.md
# Load/Store Address Generator

This block sits in the address stage of a 32-bit load/store pipeline. It takes a base register value and an offset that has already been formed, either from an immediate or from a shifted register. It returns the effective memory address and the value to write back to the base register, with an enable that says whether that writeback should happen. Selects on the input side choose add or subtract, the indexing mode, program-counter-relative addressing, load or store, and word or byte size.

Five addressing forms are supported: zero offset, pre-indexed, pre-indexed with writeback, post-indexed, and program-counter-relative. The program-counter-relative form replaces the base with the supplied program counter value, adds the offset before the access, and never writes back. A word store whose address is not on a word boundary is flagged as an error, and its writeback is cancelled.

Results are registered behind a valid/ready handshake. A result stays on the outputs until the consumer accepts it.

Top module: `ls_agu`

## Requirements
- R1: With mode 2'b00 (zero offset), `addr` equals the base and `wb_en` is 0.
- R2: With mode 2'b01 (pre-indexed), `addr` equals base plus or minus offset, `new_base` equals the unmodified base, and `wb_en` is 0.
- R3: With mode 2'b10 (pre-indexed with writeback), `addr` and `new_base` both equal base plus or minus offset, and `wb_en` is 1 unless R7 applies.
- R4: With mode 2'b11 (post-indexed), `addr` equals the unmodified base, `new_base` equals base plus or minus offset, and `wb_en` is 1 unless R7 applies.
- R5: `sub_off`=1 subtracts the offset from the base, and `sub_off`=0 adds it. The arithmetic wraps modulo 2^32 (for example 4 minus 8 gives 0xFFFFFFFC).
- R6: With `pc_rel`=1, `pc_val` replaces `base_val`. `addr` is `pc_val` plus or minus offset, whatever the mode is, and `wb_en` is 0.
- R7: When `is_store`=1 and `is_word`=1 and the two low bits of `addr` are not both zero, `misalign` is 1 and `wb_en` is 0. Byte stores and loads never raise `misalign`.
- R8: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid`=1 and `out_ready`=0, all outputs hold their values.
- R9: After reset, `out_valid`, `wb_en` and `misalign` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | A request can be taken this cycle |
| base_val | input | AW | Base register value |
| pc_val | input | AW | Program counter value used for relative addressing |
| offset | input | AW | Offset magnitude, already formed |
| sub_off | input | 1 | 1 = subtract the offset, 0 = add it |
| mode | input | 2 | 00 zero, 01 pre, 10 pre with writeback, 11 post |
| pc_rel | input | 1 | Use `pc_val` as the base, pre-indexed, no writeback |
| is_store | input | 1 | 1 = store, 0 = load |
| is_word | input | 1 | 1 = word access, 0 = byte access |
| out_valid | output | 1 | A registered result is present |
| out_ready | input | 1 | The consumer takes the result |
| addr | output | AW | Effective address |
| new_base | output | AW | Base writeback value |
| wb_en | output | 1 | Write `new_base` to the base register |
| misalign | output | 1 | Misaligned word store |

## Verification
The assertions check the following on every cycle: held outputs during a stall, the ready rule, that a flagged transfer never writes back, that a flagged address really is unaligned, and that accepted zero-offset, post-indexed and program-counter-relative requests produce the required address and writeback enable. The bench scenarios cover the rest. These are exact sums and differences, wraparound on subtraction, the separate treatment of byte stores and word loads at unaligned addresses, the reset state, and the refusal of a second request while the output is stalled.

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] offset,
  input  logic          sub_off,
  input  logic [1:0]    mode,
  input  logic          pc_rel,
  input  logic          is_store,
  input  logic          is_word,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_base,
  output logic          wb_en,
  output logic          misalign
);
  localparam int LSBS = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam logic [1:0] M_ZERO = 2'b00, M_PRE = 2'b01, M_PREWB = 2'b10, M_POST = 2'b11;

  logic [AW-1:0] base_sel, sum, ea_n, nb_n;
  logic          wb_req, mis_n, accept;

  assign base_sel = pc_rel ? pc_val : base_val;
  assign sum      = sub_off ? base_sel - offset : base_sel + offset;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    ea_n   = base_sel;
    nb_n   = base_sel;
    wb_req = 1'b0;
    if (pc_rel) begin
      ea_n = sum;
    end else begin
      case (mode)
        M_ZERO:  ea_n = base_sel;
        M_PRE:   ea_n = sum;
        M_PREWB: begin ea_n = sum; nb_n = sum; wb_req = 1'b1; end
        M_POST:  begin ea_n = base_sel; nb_n = sum; wb_req = 1'b1; end
        default: ea_n = base_sel;
      endcase
    end
  end

  assign mis_n = is_store && is_word && (WORD_BYTES > 1) && (ea_n[LSBS-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      addr      <= '0;
      new_base  <= '0;
      wb_en     <= 1'b0;
      misalign  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      addr      <= ea_n;
      new_base  <= nb_n;
      wb_en     <= wb_req && !mis_n;
      misalign  <= mis_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      misalign  <= 1'b0;
    end
  end
endmodule

module ls_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] pc_val,
  input logic [1:0]    mode,
  input logic          pc_rel,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] new_base,
  input logic          wb_en,
  input logic          misalign
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(addr) && $stable(new_base)
                                   && $stable(wb_en) && $stable(misalign)));
  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
  // R7
  mis_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !wb_en);
  // R7
  mis_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (addr[1:0] != 2'b00));
  // R1
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pc_rel && mode == 2'b00) |=> (!wb_en && addr == $past(base_val)));
  // R4
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pc_rel && mode == 2'b11) |=> (addr == $past(base_val)));
  // R6
  pc_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pc_rel) |=> !wb_en);
endmodule

bind ls_agu ls_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .base_val(base_val), .pc_val(pc_val), .mode(mode), .pc_rel(pc_rel),
  .out_valid(out_valid), .out_ready(out_ready), .addr(addr),
  .new_base(new_base), .wb_en(wb_en), .misalign(misalign)
);

// File: tb/tb_ls_agu.sv
module tb_ls_agu;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, in_ready, sub_off = 0, pc_rel = 0, is_store = 0, is_word = 1;
  logic [31:0] base_val = 0, pc_val = 0, offset = 0, addr, new_base;
  logic [1:0]  mode = 0;
  logic        out_valid, out_ready = 1, wb_en, misalign;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  ls_agu dut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(logic [31:0] b, logic [31:0] off, logic s, logic [1:0] m,
                       logic pr, logic st, logic wd);
    @(negedge clk);
    base_val = b; offset = off; sub_off = s; mode = m; pc_rel = pr;
    is_store = st; is_word = wd; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    chk("R9 out_valid", {31'b0, out_valid}, 0);
    chk("R9 wb_en", {31'b0, wb_en}, 0);
    chk("R9 misalign", {31'b0, misalign}, 0);
    chk("R9 in_ready", {31'b0, in_ready}, 1);
  endtask

  task automatic t_zero();
    issue(32'h1000, 32'h40, 0, 2'b00, 0, 0, 1);
    chk("R1 addr", addr, 32'h1000);
    chk("R1 wb_en", {31'b0, wb_en}, 0);
  endtask

  task automatic t_pre();
    issue(32'h2000, 32'd960, 0, 2'b01, 0, 0, 1);
    chk("R2 addr", addr, 32'h23C0);
    chk("R2 new_base", new_base, 32'h2000);
    chk("R2 wb_en", {31'b0, wb_en}, 0);
  endtask

  task automatic t_prewb();
    issue(32'h2000, 32'd960, 0, 2'b10, 0, 1, 1);
    chk("R3 addr", addr, 32'h23C0);
    chk("R3 new_base", new_base, 32'h23C0);
    chk("R3 wb_en", {31'b0, wb_en}, 1);
  endtask

  task automatic t_post_sub();
    issue(32'h3000, 32'd8, 1, 2'b11, 0, 1, 1);
    chk("R4 addr", addr, 32'h3000);
    chk("R4 R5 new_base", new_base, 32'h2FF8);
    chk("R4 wb_en", {31'b0, wb_en}, 1);
  endtask

  task automatic t_wrap();
    issue(32'h4, 32'd8, 1, 2'b01, 0, 0, 1);
    chk("R5 wrap addr", addr, 32'hFFFF_FFFC);
    issue(32'hFFFF_FFFC, 32'd12, 0, 2'b10, 0, 0, 1);
    chk("R5 wrap add", new_base, 32'h8);
  endtask

  task automatic t_pcrel();
    pc_val = 32'h8000;
    issue(32'h1234, 32'd4095, 0, 2'b10, 1, 0, 1);
    chk("R6 addr", addr, 32'h8FFF);
    chk("R6 wb_en", {31'b0, wb_en}, 0);
    issue(32'h1234, 32'd16, 1, 2'b11, 1, 0, 1);
    chk("R6 sub addr", addr, 32'h7FF0);
  endtask

  task automatic t_misalign();
    issue(32'h100, 32'd2, 0, 2'b10, 0, 1, 1);
    chk("R7 word store flag", {31'b0, misalign}, 1);
    chk("R7 word store wb", {31'b0, wb_en}, 0);
    issue(32'h100, 32'd2, 0, 2'b10, 0, 1, 0);
    chk("R7 byte store flag", {31'b0, misalign}, 0);
    chk("R7 byte store wb", {31'b0, wb_en}, 1);
    issue(32'h101, 32'd0, 0, 2'b11, 0, 0, 1);
    chk("R7 word load flag", {31'b0, misalign}, 0);
    issue(32'h103, 32'd1, 0, 2'b11, 0, 1, 1);
    chk("R7 post base unaligned", {31'b0, misalign}, 1);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 0;
    issue(32'h5000, 32'd4, 0, 2'b10, 0, 1, 1);
    chk("R8 valid", {31'b0, out_valid}, 1);
    chk("R8 not ready", {31'b0, in_ready}, 0);
    base_val = 32'h6000; mode = 2'b00; in_valid = 1;
    repeat (3) @(negedge clk);
    chk("R8 addr held", addr, 32'h5004);
    chk("R8 nb held", new_base, 32'h5004);
    chk("R8 wb held", {31'b0, wb_en}, 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 new taken", addr, 32'h6000);
    @(negedge clk);
    chk("R8 drained", {31'b0, out_valid}, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_pre();
    t_prewb();
    t_post_sub();
    t_wrap();
    t_pcrel();
    t_misalign();
    t_stall();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule